// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over a 16-bit Management Bus

This block lets a host issue 32-bit register reads and writes into a wide switch register space that can only be reached through a narrow 16-bit management bus. The wide space is split into pages. A page-select register sits at a fixed management address. The rest of the address picks one register from a window of 16-bit registers, and that window is spread across eight consecutive PHY addresses.

Each host access turns into exactly three management accesses. The first is always a page write. Two data-half accesses follow, and their order depends on the direction. Reads fetch the low half first, so that counters which clear on read latch in the right order. Writes store the high half first, so that a busy or trigger bit in the low half fires only after the whole word is in place.

The host side is a request/ready handshake with a single-cycle done pulse. The management side presents one access at a time and holds it until the bus agent answers with done. The serial signalling itself belongs to a separate agent.

Top module: `paged_reg_bridge`

## Requirements
- R1: While reset is held and in the cycle after it, `req_ready_o` is 1, and both `mg_req_o` and `rsp_done_o` are 0.
- R2: A request is accepted at a clock edge where `req_valid_i` and `req_ready_o` are both 1. From that edge until the edge after the done pulse, `req_ready_o` is 0. Host inputs that change or stay valid during this time have no effect on the sequence in progress.
- R3: The first management access of every sequence is a write to PHY address 0x18, register 0. The write data is bits 16:8 of the word address, zero-extended to 16 bits.
- R4: The word address is the byte address with bits 1:0 cleared, shifted right by one. The low half uses this word address and the high half uses the word address plus one. Each half goes to PHY address 0x10 OR'd with word-address bits 7:5, at register number word-address bits 4:0. The page is not rewritten for the high half.
- R5: A read performs the page write, then a read of the low half, then a read of the high half. When done pulses, `rsp_rdata_o` equals {high, low}.
- R6: A write performs the page write, then a write of host data bits 31:16 to the high half, then a write of bits 15:0 to the low half.
- R7: While `mg_req_o` is 1 and `mg_done_i` is 0, the request and all its fields hold steady. A `mg_done_i` pulse when no request is pending changes nothing.
- R8: `rsp_done_o` pulses for exactly one cycle per accepted request. It is 1 in the cycle after the edge that completes the third management access, and `req_ready_o` returns to 1 in the cycle after that.
- R9: Byte-address bits 1:0 do not affect which registers are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Bridge idle and able to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | HOST_AW (18) | Host byte address |
| req_wdata_i | input | 2*DATA_W (32) | Host write data |
| rsp_done_o | output | 1 | Single-cycle completion pulse |
| rsp_rdata_o | output | 2*DATA_W (32) | Read result, valid with `rsp_done_o` |
| mg_req_o | output | 1 | Management access pending |
| mg_write_o | output | 1 | Management access is a write |
| mg_phy_o | output | PHY_W (5) | Management PHY address |
| mg_reg_o | output | REG_W (5) | Management register number |
| mg_wdata_o | output | DATA_W (16) | Management write data |
| mg_rdata_i | input | DATA_W (16) | Management read data, sampled with `mg_done_i` |
| mg_done_i | input | 1 | Management access complete |

## Verification
Some properties are checked by assertions on every cycle:
- the handshake (ready drops after acceptance and comes back after a one-cycle done pulse);
- every sequence opening with the page write;
- the management request holding its fields steady until done;
- the first data access touching the even register for reads and the odd one for writes.

Other behaviour only the bench scenarios can show. These are the exact page and window addresses derived from each host address, the assembled 32-bit read value, that write data lands in the right halves, that ignored byte-offset bits and stray done pulses leave no trace, and that a request held valid while busy is not picked up. The bench shows them by checking against a behavioural register-file responder with varying answer latency.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PAGE   = 3'd1,
    ST_FIRST  = 3'd2,
    ST_SECOND = 3'd3,
    ST_RESP   = 3'd4
  } seq_state_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // reads: low then high; writes: high then low
  function automatic half_e half_of(seq_state_e st, logic wr);
    if (st == ST_FIRST) return wr ? HALF_HI : HALF_LO;
    return wr ? HALF_LO : HALF_HI;
  endfunction

endpackage

// File: rtl/bridge_addr_map.sv
module bridge_addr_map #(
  parameter int unsigned HOST_AW      = 18,
  parameter int unsigned PHY_W        = 5,
  parameter int unsigned REG_W        = 5,
  parameter int unsigned WIN_SEL_W    = 3,
  parameter logic [PHY_W-1:0] WIN_PHY_BASE = 5'h10,
  localparam int unsigned WORD_AW     = HOST_AW - 1,
  localparam int unsigned WIN_LSB_W   = REG_W + WIN_SEL_W,
  localparam int unsigned PAGE_W      = WORD_AW - WIN_LSB_W
) (
  input  logic [HOST_AW-3:0]           dword_addr_i,
  output logic [PAGE_W-1:0]            page_o,
  output logic [1:0][PHY_W-1:0]        phy_o,
  output logic [1:0][REG_W-1:0]        reg_o
);

  logic [WORD_AW-1:0] word_lo;
  assign word_lo = {dword_addr_i, 1'b0};

  // page taken once from the low word; high half never re-pages
  assign page_o = word_lo[WORD_AW-1:WIN_LSB_W];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [WIN_LSB_W-1:0] word_h;
    assign word_h   = word_lo[WIN_LSB_W-1:0] + WIN_LSB_W'(h);
    assign phy_o[h] = WIN_PHY_BASE |
                      {{(PHY_W-WIN_SEL_W){1'b0}}, word_h[WIN_LSB_W-1:REG_W]};
    assign reg_o[h] = word_h[REG_W-1:0];
  end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_valid_i,
  input  logic       write_q_i,
  input  logic       mg_done_i,
  output logic       host_ready_o,
  output logic       host_done_o,
  output logic       accept_o,
  output logic       mg_req_o,
  output logic       cap_en_o,
  output logic       cap_hi_o,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (host_valid_i) state_d = ST_PAGE;
      ST_PAGE:   if (mg_done_i)    state_d = ST_FIRST;
      ST_FIRST:  if (mg_done_i)    state_d = ST_SECOND;
      ST_SECOND: if (mg_done_i)    state_d = ST_RESP;
      ST_RESP:                     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  logic data_step;
  assign data_step    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign host_ready_o = (state_q == ST_IDLE);
  assign host_done_o  = (state_q == ST_RESP);
  assign accept_o     = host_valid_i && host_ready_o;
  assign mg_req_o     = (state_q == ST_PAGE) || data_step;
  assign cap_en_o     = data_step && mg_done_i && !write_q_i;
  assign cap_hi_o     = (half_of(state_q, write_q_i) == HALF_HI);
  assign state_o      = state_q;

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !host_ready_o);

  p_ready_only_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> (!mg_req_o && !host_done_o));

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mg_req_o && !mg_done_i) |=> mg_req_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |=> (!host_done_o && host_ready_o));

endmodule

// File: rtl/bridge_cmd_mux.sv
module bridge_cmd_mux
  import bridge_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PHY_W    = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned PAGE_W   = 9,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h18,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h00
) (
  input  seq_state_e                 state_i,
  input  logic                       write_q_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [1:0][PHY_W-1:0]      phy_i,
  input  logic [1:0][REG_W-1:0]      reg_i,
  input  logic [2*DATA_W-1:0]        wdata_q_i,
  output logic                       mg_write_o,
  output logic [PHY_W-1:0]           mg_phy_o,
  output logic [REG_W-1:0]           mg_reg_o,
  output logic [DATA_W-1:0]          mg_wdata_o
);

  half_e half;
  assign half = half_of(state_i, write_q_i);

  always_comb begin
    mg_write_o = 1'b0;
    mg_phy_o   = '0;
    mg_reg_o   = '0;
    mg_wdata_o = '0;
    unique case (state_i)
      ST_PAGE: begin
        mg_write_o = 1'b1;
        mg_phy_o   = PAGE_PHY;
        mg_reg_o   = PAGE_REG;
        mg_wdata_o = {{(DATA_W-PAGE_W){1'b0}}, page_i};
      end
      ST_FIRST, ST_SECOND: begin
        mg_write_o = write_q_i;
        mg_phy_o   = phy_i[half];
        mg_reg_o   = reg_i[half];
        if (write_q_i)
          mg_wdata_o = (half == HALF_HI) ? wdata_q_i[2*DATA_W-1:DATA_W]
                                         : wdata_q_i[DATA_W-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bridge_rdata.sv
module bridge_rdata #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_en_i,
  input  logic                cap_hi_i,
  input  logic [DATA_W-1:0]   mg_rdata_i,
  output logic [2*DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cap_en_i) begin
      if (cap_hi_i) hi_q <= mg_rdata_i;
      else          lo_q <= mg_rdata_i;
    end
  end

  assign rdata_o = {hi_q, lo_q};

endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned HOST_AW   = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PHY_W     = 5,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned WIN_SEL_W = 3,
  parameter logic [PHY_W-1:0] PAGE_PHY     = 5'h18,
  parameter logic [REG_W-1:0] PAGE_REG     = 5'h00,
  parameter logic [PHY_W-1:0] WIN_PHY_BASE = 5'h10,
  localparam int unsigned WORD_AW   = HOST_AW - 1,
  localparam int unsigned PAGE_W    = WORD_AW - REG_W - WIN_SEL_W,
  localparam int unsigned HOST_DW   = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [HOST_AW-1:0] req_addr_i,
  input  logic [HOST_DW-1:0] req_wdata_i,
  output logic               rsp_done_o,
  output logic [HOST_DW-1:0] rsp_rdata_o,
  output logic               mg_req_o,
  output logic               mg_write_o,
  output logic [PHY_W-1:0]   mg_phy_o,
  output logic [REG_W-1:0]   mg_reg_o,
  output logic [DATA_W-1:0]  mg_wdata_o,
  input  logic [DATA_W-1:0]  mg_rdata_i,
  input  logic               mg_done_i
);

  // byte offset inside the 32-bit word is dropped by design
  logic unused_lsb;
  assign unused_lsb = ^req_addr_i[1:0];

  logic               accept;
  logic               write_q;
  logic [HOST_AW-3:0] dword_q;
  logic [HOST_DW-1:0] wdata_q;
  logic               cap_en, cap_hi;
  seq_state_e         state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      dword_q <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      dword_q <= req_addr_i[HOST_AW-1:2];
      wdata_q <= req_wdata_i;
    end
  end

  logic [PAGE_W-1:0]     page;
  logic [1:0][PHY_W-1:0] half_phy;
  logic [1:0][REG_W-1:0] half_reg;

  bridge_addr_map #(
    .HOST_AW     (HOST_AW),
    .PHY_W       (PHY_W),
    .REG_W       (REG_W),
    .WIN_SEL_W   (WIN_SEL_W),
    .WIN_PHY_BASE(WIN_PHY_BASE)
  ) u_addr_map (
    .dword_addr_i(dword_q),
    .page_o      (page),
    .phy_o       (half_phy),
    .reg_o       (half_reg)
  );

  bridge_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_valid_i(req_valid_i),
    .write_q_i   (write_q),
    .mg_done_i   (mg_done_i),
    .host_ready_o(req_ready_o),
    .host_done_o (rsp_done_o),
    .accept_o    (accept),
    .mg_req_o    (mg_req_o),
    .cap_en_o    (cap_en),
    .cap_hi_o    (cap_hi),
    .state_o     (state)
  );

  bridge_cmd_mux #(
    .DATA_W  (DATA_W),
    .PHY_W   (PHY_W),
    .REG_W   (REG_W),
    .PAGE_W  (PAGE_W),
    .PAGE_PHY(PAGE_PHY),
    .PAGE_REG(PAGE_REG)
  ) u_cmd_mux (
    .state_i   (state),
    .write_q_i (write_q),
    .page_i    (page),
    .phy_i     (half_phy),
    .reg_i     (half_reg),
    .wdata_q_i (wdata_q),
    .mg_write_o(mg_write_o),
    .mg_phy_o  (mg_phy_o),
    .mg_reg_o  (mg_reg_o),
    .mg_wdata_o(mg_wdata_o)
  );

  bridge_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .cap_hi_i  (cap_hi),
    .mg_rdata_i(mg_rdata_i),
    .rdata_o   (rsp_rdata_o)
  );

  p_page_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (mg_req_o && mg_write_o && mg_phy_o == PAGE_PHY && mg_reg_o == PAGE_REG));

  p_cmd_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mg_req_o && !mg_done_i) |=> $stable({mg_write_o, mg_phy_o, mg_reg_o, mg_wdata_o}));

  p_window_phy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mg_req_o && state != ST_PAGE) |-> ((mg_phy_o & WIN_PHY_BASE) == WIN_PHY_BASE));

  p_half_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIRST && !mg_write_o) |-> !mg_reg_o[0]);

  p_half_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIRST && mg_write_o) |-> mg_reg_o[0]);

endmodule

// File: tb/paged_reg_bridge_bench.sv
module paged_reg_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_done, mg_req, mg_write;
  logic [31:0] rsp_rdata;
  logic [4:0]  mg_phy, mg_reg;
  logic [15:0] mg_wdata;
  logic [15:0] mg_rdata = '0;
  logic        mg_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_reg_bridge u_paged_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mg_req_o(mg_req), .mg_write_o(mg_write), .mg_phy_o(mg_phy), .mg_reg_o(mg_reg),
    .mg_wdata_o(mg_wdata), .mg_rdata_i(mg_rdata), .mg_done_i(mg_done)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural register file behind the management bus
  logic [15:0] mem [int];
  logic [8:0]  cur_page = '0;

  function automatic logic [15:0] rd_word(input logic [16:0] w);
    if (mem.exists(int'(w))) return mem[int'(w)];
    return w[15:0] ^ 16'hA5C3;
  endfunction

  // expected management accesses, in order
  bit          q_w[$];
  logic [4:0]  q_phy[$], q_reg[$];
  logic [15:0] q_wd[$];
  string       q_tag[$];

  int lat = 0, wait_cnt = 0, acc_cnt = 0;
  bit stray = 0, in_stray = 0;

  task automatic do_access();
    bit ew; logic [4:0] ep, er; logic [15:0] ed; string et;
    logic [16:0] w;
    if (q_w.size() == 0) begin
      chk(0, "R2 unexpected access", {22'd0, mg_phy, mg_reg}, 32'd0);
      return;
    end
    ew = q_w.pop_front(); ep = q_phy.pop_front(); er = q_reg.pop_front();
    ed = q_wd.pop_front(); et = q_tag.pop_front();
    chk(mg_write == ew, {et, " write flag"}, {31'd0, mg_write}, {31'd0, ew});
    chk(mg_phy == ep, {et, " phy"}, {27'd0, mg_phy}, {27'd0, ep});
    chk(mg_reg == er, {et, " reg"}, {27'd0, mg_reg}, {27'd0, er});
    if (ew) chk(mg_wdata == ed, {et, " wdata"}, {16'd0, mg_wdata}, {16'd0, ed});
    if (mg_write && mg_phy == 5'h18 && mg_reg == 5'h00) cur_page = mg_wdata[8:0];
    else begin
      w = {cur_page, mg_phy[2:0], mg_reg};
      if (mg_write) mem[int'(w)] = mg_wdata;
      else mg_rdata = rd_word(w);
    end
  endtask

  // responder plus per-clock done model
  always @(negedge clk) begin
    bit exp_done;
    exp_done = 0;
    if (rst_n) begin
      if (mg_done) begin
        mg_done = 0;
        wait_cnt = 0;
        if (in_stray) in_stray = 0;
        else begin
          acc_cnt++;
          if (acc_cnt == 3) begin exp_done = 1; acc_cnt = 0; end
        end
      end else if (mg_req) begin
        if (wait_cnt == lat) begin do_access(); mg_done = 1; end
        else wait_cnt++;
      end else if (stray) begin
        stray = 0; in_stray = 1; mg_done = 1;
      end
      chk(rsp_done == exp_done, "R8 done timing", {31'd0, rsp_done}, {31'd0, exp_done});
    end
  end

  task automatic host_op(input bit wr, input logic [17:0] a, input logic [31:0] wd, input bit junk);
    logic [16:0] w;
    logic [4:0]  ph, rl, rh;
    logic [31:0] exp;
    w  = {a[17:2], 1'b0};
    ph = 5'h10 | {2'b00, w[7:5]};
    rl = w[4:0];
    rh = w[4:0] | 5'd1;
    q_w.push_back(1); q_phy.push_back(5'h18); q_reg.push_back(5'h00);
    q_wd.push_back({7'd0, w[16:8]}); q_tag.push_back("R3 page");
    if (wr) begin
      q_w.push_back(1); q_phy.push_back(ph); q_reg.push_back(rh); q_wd.push_back(wd[31:16]); q_tag.push_back("R6 high first");
      q_w.push_back(1); q_phy.push_back(ph); q_reg.push_back(rl); q_wd.push_back(wd[15:0]);  q_tag.push_back("R6 low second");
    end else begin
      q_w.push_back(0); q_phy.push_back(ph); q_reg.push_back(rl); q_wd.push_back('0); q_tag.push_back("R5/R4 low first");
      q_w.push_back(0); q_phy.push_back(ph); q_reg.push_back(rh); q_wd.push_back('0); q_tag.push_back("R5/R4 high second");
    end
    exp = {rd_word(w | 17'd1), rd_word(w)};
    @(negedge clk);
    chk(req_ready == 1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    chk(req_ready == 0, "R2 busy after accept", {31'd0, req_ready}, 32'd0);
    if (junk) begin
      req_addr = ~a; req_write = ~wr; req_wdata = ~wd;
    end else req_valid = 0;
    while (!rsp_done) @(negedge clk);
    req_valid = 0;
    if (!wr) chk(rsp_rdata == exp, "R5 read data", rsp_rdata, exp);
    @(negedge clk);
    chk(req_ready == 1, "R8 ready after done", {31'd0, req_ready}, 32'd1);
    chk(q_w.size() == 0, "R2 three accesses", q_w.size(), 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && mg_req == 0 && rsp_done == 0, "R1 reset state",
        {29'd0, req_ready, mg_req, rsp_done}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mg_req == 0 && rsp_done == 0, "R1 after reset",
        {29'd0, req_ready, mg_req, rsp_done}, 32'h4);

    // reads of untouched registers, several pages and windows
    lat = 0; host_op(0, 18'h00000, '0, 0);
    lat = 1; host_op(0, 18'h3FFFC, '0, 0);
    lat = 3; host_op(0, 18'h12A64, '0, 0);
    // R6 write then read back through both halves
    lat = 0; host_op(1, 18'h00208, 32'hDEAD_BEEF, 0);
    lat = 2; host_op(0, 18'h00208, '0, 0);
    // R9 byte offset bits ignored
    host_op(1, 18'h2F0E7, 32'h1234_5678, 0);
    host_op(0, 18'h2F0E4, '0, 0);
    host_op(0, 18'h2F0E6, '0, 0);
    // R4 top of a window (word bits 7:0 near 0xFE)
    lat = 1; host_op(1, 18'h001FC, 32'hCAFE_0001, 0);
    host_op(0, 18'h001FC, '0, 0);
    // R2 request held valid with other contents while busy
    lat = 2; host_op(1, 18'h10040, 32'hA5A5_5A5A, 1);
    host_op(0, 18'h10040, '0, 1);
    // R7 stray management done while idle
    stray = 1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1 && mg_req == 0, "R7 stray done ignored",
        {30'd0, req_ready, mg_req}, 32'h2);
    lat = 0; host_op(0, 18'h00208, '0, 0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule